// File: doc/BRIEF.md
# SPI Flash Command Engine

This block lets software run one serial-flash transaction per start command through three 32-bit registers. Software places the instruction byte and a 24-bit flash address in one register and, for program-style commands, up to four payload bytes in a data register. It then writes a control word that carries a transmit byte count, a receive byte count and a start bit. The engine drives chip select low, shifts the transmit bytes out, clocks in the requested response bytes, packs them into the data register and drops its busy flag when chip select is released.

The register port is a plain single-cycle write strobe with a combinational read path and no back-pressure: a write is taken on the clock edge where the strobe is high. The only flow control is the busy flag. Software polls it and must not rely on writes made while it is set, because the engine drops them. The serial side is an SPI master in mode 0 whose clock rate software picks with a two-bit field.

Top module: `spi_cmd_engine`

## Requirements
- R1: The register offsets are 0x0 for control, 0x4 for opcode/address and 0x8 for data. Reads at any other offset return zero. After reset every register reads zero, chip select is high and SCK is low.
- R2: Control bits [3:0] hold the transmit count and bits [7:4] the receive count. Bits [18:17] form a size field and bits [25:24] form a clock select; software can write and read all four fields. Bit 16 is the read-only busy flag. Start is bit 8 and always reads back as 0.
- R3: A control write with start=1, busy clear and a transmit count from 1 to 8 is accepted. Busy reads 1 from the next cycle and stays 1 until chip select is released.
- R4: Transmit byte 0 is opcode/address bits [7:0]. Bytes 1 to 3 are address bits [31:24], [23:16] and [15:8], in that order. Bytes 4 to 7 are data bits [7:0], [15:8], [23:16] and [31:24], in that order.
- R5: Each byte goes out MSB first in SPI mode 0. MOSI is stable at every SCK rising edge and MISO is sampled on that edge. SCK stays high for (clock select + 1) clock cycles and low for the same number of cycles.
- R6: Received byte k is stored at data bits [8k+7:8k] and unreceived bytes read zero. A receive count above 4 acts as 4. A receive count of 0 leaves the data register unchanged. MOSI is 0 during receive bytes.
- R7: Chip select stays low for the whole transaction. The first SCK rising edge comes (clock select + 1) cycles after chip select falls. Chip select rises, and busy falls, two half-periods after the last SCK falling edge. SCK is low whenever chip select is high.
- R8: A start with a transmit count of 0 or above 8 does nothing: busy stays 0 and no SCK edge appears. The other control fields of that write are still stored.
- R9: While busy is 1, writes to any register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions check the pin relations that must hold on every cycle. Chip select matches busy, SCK stays low while chip select is high, busy rises only after an accepted start, a start with an illegal count leaves the engine idle, and writes made while busy do not change the opcode register. Byte order, address and payload placement, receive packing with zero fill and clamping, and the exact SCK half-period and framing cycle counts can only be shown by the bench. The bench runs concrete commands against a modelled flash that records MOSI and replays a response on MISO.

// File: rtl/sce_pkg.sv
package sce_pkg;
  localparam int REG_W      = 32;
  localparam int BYTE_W     = 8;
  localparam int CNT_W      = 4;
  localparam int CLKSEL_W   = 2;
  localparam int TX_MAX     = 8;
  localparam int RX_MAX     = 4;
  localparam int OFS_CTRL   = 'h0;
  localparam int OFS_OPADDR = 'h4;
  localparam int OFS_DATA   = 'h8;
  localparam int BIT_START  = 8;
  localparam int BIT_BUSY   = 16;
  localparam int POS_SIZE   = 17;
  localparam int POS_CLKSEL = 24;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HI, ST_LO, ST_TAIL_A, ST_TAIL_B
  } sce_state_e;
endpackage

// File: rtl/sce_tick.sv
module sce_tick #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sce_txsel.sv
module sce_txsel
  import sce_pkg::*;
(
  input  logic [CNT_W-1:0]  idx,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic [REG_W-1:0]  opaddr,
  input  logic [REG_W-1:0]  data,
  output logic [BYTE_W-1:0] byte_o
);
  logic [REG_W-1:0] data_sh;

  assign data_sh = data >> {idx[1:0], 3'b000};

  always_comb begin
    byte_o = '0;
    if (idx < tx_cnt) begin
      case (idx)
        4'd0:    byte_o = opaddr[7:0];
        4'd1:    byte_o = opaddr[31:24];
        4'd2:    byte_o = opaddr[23:16];
        4'd3:    byte_o = opaddr[15:8];
        default: byte_o = data_sh[BYTE_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/sce_rxpack.sv
module sce_rxpack
  import sce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [1:0]        idx,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [REG_W-1:0]  word_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word_o <= '0;
    else if (clr) word_o <= '0;
    else if (we)  word_o[{idx, 3'b000} +: BYTE_W] <= byte_in;
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import sce_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  sce_state_e           state;
  logic [CNT_W-1:0]     tx_q, rx_q, byte_idx, rx_eff, total, nidx, rx_slot;
  logic [1:0]           size_q;
  logic [CLKSEL_W-1:0]  clks_q;
  logic [REG_W-1:0]     opaddr_q, data_q, rx_word;
  logic [2:0]           bit_idx;
  logic [BYTE_W-1:0]    sh_out, sh_in, next_byte;
  logic                 busy, tick, wr_ctrl, tx_ok, accept, last_bit, byte_end, rx_we;

  assign busy    = (state != ST_IDLE);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign tx_ok   = (bus_wdata[3:0] != '0) && (bus_wdata[3:0] <= CNT_W'(TX_MAX));
  assign accept  = wr_ctrl && !busy && bus_wdata[BIT_START] && tx_ok;

  assign rx_eff   = (rx_q > CNT_W'(RX_MAX)) ? CNT_W'(RX_MAX) : rx_q;
  assign total    = tx_q + rx_eff;
  assign nidx     = byte_idx + 1'b1;
  assign byte_end = (state == ST_HI) && tick && (bit_idx == 3'd0);
  assign last_bit = (byte_idx == total - 1'b1) && (bit_idx == 3'd0);
  assign rx_slot  = byte_idx - tx_q;
  assign rx_we    = byte_end && (byte_idx >= tx_q);

  sce_tick #(.W(CLKSEL_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .limit(clks_q), .tick(tick)
  );

  sce_txsel u_txsel (
    .idx(nidx), .tx_cnt(tx_q), .opaddr(opaddr_q), .data(data_q), .byte_o(next_byte)
  );

  sce_rxpack u_rxpack (
    .clk(clk), .rst_n(rst_n), .clr(accept), .we(rx_we),
    .idx(rx_slot[1:0]), .byte_in(sh_in), .word_o(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tx_q     <= '0;
      rx_q     <= '0;
      size_q   <= '0;
      clks_q   <= '0;
      opaddr_q <= '0;
      data_q   <= '0;
      byte_idx <= '0;
      bit_idx  <= '0;
      sh_out   <= '0;
      sh_in    <= '0;
    end else begin
      if (bus_wr && !busy) begin
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
          tx_q   <= bus_wdata[3:0];
          rx_q   <= bus_wdata[7:4];
          size_q <= bus_wdata[POS_SIZE +: 2];
          clks_q <= bus_wdata[POS_CLKSEL +: CLKSEL_W];
        end else if (bus_addr == ADDR_W'(OFS_OPADDR)) begin
          opaddr_q <= bus_wdata;
        end else if (bus_addr == ADDR_W'(OFS_DATA)) begin
          data_q <= bus_wdata;
        end
      end
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_LEAD;
          byte_idx <= '0;
          bit_idx  <= 3'd7;
          sh_out   <= opaddr_q[7:0];
        end
        ST_LEAD, ST_LO: if (tick) begin
          state <= ST_HI;
          sh_in <= {sh_in[BYTE_W-2:0], spi_miso};
        end
        ST_HI: if (tick) begin
          state <= last_bit ? ST_TAIL_A : ST_LO;
          if (bit_idx == 3'd0) begin
            byte_idx <= nidx;
            bit_idx  <= 3'd7;
            sh_out   <= next_byte;
          end else begin
            bit_idx <= bit_idx - 1'b1;
            sh_out  <= {sh_out[BYTE_W-2:0], 1'b0};
          end
        end
        ST_TAIL_A: if (tick) state <= ST_TAIL_B;
        ST_TAIL_B: if (tick) begin
          state <= ST_IDLE;
          if (rx_q != '0) data_q <= rx_word;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign spi_sck  = (state == ST_HI);
  assign spi_cs_n = !busy;
  assign spi_mosi = busy && sh_out[BYTE_W-1];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      bus_rdata[3:0]                   = tx_q;
      bus_rdata[7:4]                   = rx_q;
      bus_rdata[BIT_BUSY]              = busy;
      bus_rdata[POS_SIZE +: 2]         = size_q;
      bus_rdata[POS_CLKSEL +: CLKSEL_W] = clks_q;
    end else if (bus_addr == ADDR_W'(OFS_OPADDR)) begin
      bus_rdata = opaddr_q;
    end else if (bus_addr == ADDR_W'(OFS_DATA)) begin
      bus_rdata = data_q;
    end
  end
endmodule

// File: rtl/sce_checker.sv
module sce_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_start,
  input logic [3:0]        wr_tx,
  input logic              spi_sck,
  input logic              spi_cs_n,
  input logic              busy,
  input logic [31:0]       opaddr_q
);
  logic ctrl_wr;
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(0));

  assert_idle_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_cs_n && !spi_sck));

  assert_cs_framed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !spi_cs_n);

  assert_busy_from_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctrl_wr && wr_start));

  assert_bad_count_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_start && !busy && ((wr_tx == 4'd0) || (wr_tx > 4'd8))) |=> !busy);

  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && (bus_addr == ADDR_W'(4))) |=> $stable(opaddr_q));
endmodule

bind spi_cmd_engine sce_checker #(.ADDR_W(ADDR_W)) u_sce_checker (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wr_start(bus_wdata[8]), .wr_tx(bus_wdata[3:0]),
  .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .busy(busy), .opaddr_q(opaddr_q)
);

// File: tb/spi_cmd_engine_test.sv
`timescale 1ns/1ps
module spi_cmd_engine_test;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  spi_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // flash model: records MOSI, replays response bytes after the transmit bytes
  int          nbits = 0, cur_tx = 0;
  logic [31:0] cur_resp = 0;
  logic [95:0] cap;
  always @(negedge spi_cs_n or posedge spi_sck) begin
    if (spi_sck) begin
      if (nbits < 96) cap[nbits] = spi_mosi;
      nbits = nbits + 1;
    end else nbits = 0;
  end
  always_comb begin
    int j;
    j = nbits - 8 * cur_tx;
    spi_miso = 1'b1;
    if (j >= 0 && j < 32) spi_miso = cur_resp[8 * (j / 8) + 7 - (j % 8)];
  end

  // edge monitor
  int cyc = 0, rises = 0, first_rise = 0, second_rise = 0, last_fall = 0, cs_fall = 0, cs_rise = 0;
  logic p_sck = 0, p_cs = 1;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (spi_sck && !p_sck) begin
      rises = rises + 1;
      if (rises == 1) first_rise = cyc;
      if (rises == 2) second_rise = cyc;
    end
    if (!spi_sck && p_sck) last_fall = cyc;
    if (!spi_cs_n && p_cs) cs_fall = cyc;
    if (spi_cs_n && !p_cs) cs_rise = cyc;
    p_sck = spi_sck;
    p_cs  = spi_cs_n;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL watchdog: run did not finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    d = 32'h1_0000;
    while (d[16]) rd(4'h0, d);
  endtask

  function automatic logic [7:0] exp_byte(logic [31:0] oa, logic [31:0] dt, int tx, int i);
    if (i >= tx) return 8'h00;
    case (i)
      0: return oa[7:0];
      1: return oa[31:24];
      2: return oa[23:16];
      3: return oa[15:8];
      default: return dt[8 * (i - 4) +: 8];
    endcase
  endfunction

  // vectors: opaddr, data, flash response, tx count, rx count, clock select
  localparam int NV = 7;
  localparam logic [105:0] VEC [NV] = '{
    {32'h0000_0006, 32'h1357_9BDF, 32'hFFFF_FFFF, 4'd1, 4'd0, 2'd0},
    {32'h0000_0005, 32'h0000_0000, 32'hDEAD_BE5A, 4'd1, 4'd1, 2'd0},
    {32'h0000_00AB, 32'h0000_0000, 32'h0000_0017, 4'd4, 4'd1, 2'd1},
    {32'h1234_5603, 32'h0000_0000, 32'hCAFE_F00D, 4'd4, 4'd4, 2'd3},
    {32'h00AB_CD02, 32'h4433_2211, 32'h0000_0000, 4'd8, 4'd0, 2'd0},
    {32'h0102_030B, 32'h0000_0000, 32'h9988_7766, 4'd5, 4'd3, 2'd2},
    {32'h7700_0003, 32'h0000_0000, 32'h0BAD_F00D, 4'd2, 4'd7, 2'd1}
  };

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(4'h0, d); chk(d == 0, "R1 ctrl reset", d, 0);
    rd(4'h4, d); chk(d == 0, "R1 opaddr reset", d, 0);
    rd(4'h8, d); chk(d == 0, "R1 data reset", d, 0);
    chk(spi_cs_n === 1 && spi_sck === 0, "R1 pins reset", {spi_cs_n, spi_sck}, 2'b10);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] oa, dt, rs, expd;
      int tx, rx, rxe, nb;
      logic [95:0] expbits;
      {oa, dt, rs} = VEC[v][105:10];
      tx = int'(VEC[v][9:6]); rx = int'(VEC[v][5:2]);
      rxe = (rx > 4) ? 4 : rx;
      nb = tx + rxe;
      cur_tx = tx; cur_resp = rs;
      wr(4'h8, dt);
      wr(4'h4, oa);
      rises = 0;
      wr(4'h0, {6'd0, VEC[v][1:0], 15'd0, 1'b1, VEC[v][5:2], VEC[v][9:6]});
      wait_idle();
      expbits = '0;
      for (int i = 0; i < nb; i++) begin
        logic [7:0] b;
        b = exp_byte(oa, dt, tx, i);
        for (int k = 0; k < 8; k++) expbits[8 * i + k] = b[7 - k];
      end
      chk(rises == 8 * nb, "R5 sck rising count", 96'(rises), 96'(8 * nb));
      chk((cap & ((96'd1 << (8 * nb)) - 1)) == expbits, "R4 mosi byte stream", cap, expbits);
      expd = (rxe == 0) ? dt : (rs & ((rxe == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * rxe)) - 1)));
      rd(4'h8, d); chk(d == expd, "R6 received data packing", d, expd);
    end

    // R2 / R8: field retention, start with count 0 is a no-op
    rises = 0;
    wr(4'h0, 32'h0306_0150);
    rd(4'h0, d); chk(d == 32'h0306_0050, "R2 fields kept, start reads 0, busy 0 (R8)", d, 32'h0306_0050);
    // R8: count 9 is a no-op
    wr(4'h0, 32'h0000_0109);
    chk(spi_cs_n === 1, "R8 cs stays high for count 9", spi_cs_n, 1);
    repeat (20) @(negedge clk);
    chk(rises == 0, "R8 no sck edges", 96'(rises), 0);

    // R3 / R9: writes during busy ignored
    wr(4'h4, 32'h0000_00C7); wr(4'h8, 32'h5555_AAAA);
    cur_tx = 1;
    wr(4'h0, 32'h0300_0101);
    rd(4'h0, d); chk(d[16] == 1'b1, "R3 busy after start", d, 32'h0301_0001);
    wr(4'h4, 32'hFFFF_FFFF); wr(4'h8, 32'h1111_1111); wr(4'h0, 32'h0000_0148);
    wait_idle();
    rd(4'h4, d); chk(d == 32'h0000_00C7, "R9 opaddr unchanged", d, 32'hC7);
    rd(4'h8, d); chk(d == 32'h5555_AAAA, "R9 data unchanged", d, 32'h5555_AAAA);
    rd(4'h0, d); chk(d == 32'h0300_0001, "R9 ctrl unchanged", d, 32'h0300_0001);

    // R5 / R7: timing with clock select 2 (half period 3)
    rises = 0;
    wr(4'h0, 32'h0200_0101);
    wait_idle();
    chk(first_rise - cs_fall == 3, "R7 cs fall to first rise", 96'(first_rise - cs_fall), 3);
    chk(second_rise - first_rise == 6, "R5 sck period", 96'(second_rise - first_rise), 6);
    chk(cs_rise - last_fall == 6, "R7 last fall to cs rise", 96'(cs_rise - last_fall), 6);

    // R1: unmapped offset
    rd(4'hC, d); chk(d == 0, "R1 unmapped offset", d, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule